// File: doc/BRIEF.md
# Cascadable Serial Segment Display Driver

This block is the logic core of a display driver for static liquid crystal panels. Segment data arrives one bit at a time on a slow serial clock and moves through a 38-stage shift register. It shifts only while the active-low select is asserted. A load strobe copies the register into a display latch. If the strobe stays high while data is shifting, the latch follows the register.

Every segment output combines its latched bit with a backplane square wave. A latched one drives the segment opposite to the backplane, which makes it visible. A latched zero drives it in step with the backplane, which leaves it blank. The backplane comes from a display clock input, selected by a mode input. In one mode the display clock passes straight through. In the other it is divided by 256.

Three chain outputs carry the register contents at stages 30, 32 and 38, so several drivers can be connected in series. The drivers share the serial clock, the select and the load strobe. Each driver's chain output feeds the next driver's data input. The chain outputs change on the rising serial clock edge, half a serial cycle after the shift. A fast system clock samples all asynchronous inputs through two-flop synchronizers and detects the serial clock edges.

Top module: `segdrv_top`

## Requirements
- R1: On each falling edge of `ser_clk` while `sel_n` is 0, the register moves one place away from the input. Bit 0 takes `ser_din`, and bit i takes the old bit i-1.
- R2: A falling edge of `ser_clk` while `sel_n` is 1 leaves the register unchanged.
- R3: While `load` is 1, the latch copies the register. If `load` stays 1 during shifting, the latch follows each shift.
- R4: While `load` is 0, the latch and the segment data hold, whatever happens on the serial inputs.
- R5: `seg_out[i]` is `~bp_out` when latch bit i is 1, and equals `bp_out` when latch bit i is 0.
- R6: With `bp_mode` = 1, `bp_out` is bit 7 of a counter of `disp_clk` rising edges. After reset it first goes to 1 on the 128th rise and returns to 0 on the 256th.
- R7: With `bp_mode` = 0, `bp_out` follows `disp_clk` in phase, after the synchronizer delay.
- R8: `chain_out[0]`, `chain_out[1]` and `chain_out[2]` carry register bits 29, 31 and 37. They are registered only on a rising edge of `ser_clk`.
- R9: After reset, the register, the latch, the divider and the chain outputs are all 0. `bp_out` is 0 and every segment equals `bp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (shifts on fall, chain outputs on rise) |
| ser_din | input | 1 | Serial data input |
| sel_n | input | 1 | Active-low shift enable |
| load | input | 1 | Latch load / transparency strobe |
| disp_clk | input | 1 | Display clock for the backplane |
| bp_mode | input | 1 | 0: backplane follows disp_clk, 1: disp_clk divided by 256 |
| seg_out | output | 38 | Segment drive outputs |
| bp_out | output | 1 | Backplane drive output |
| chain_out | output | 3 | Register taps at stages 30, 32, 38 |

## Verification
The assertions check the register-level rules on every system cycle. The register shifts only on a selected falling edge, and each shift moves in the expected data. The latch copies the register while the strobe is high and holds while it is low. The chain outputs and the divided backplane stay still between their triggering edges.

Some behaviours can only be shown by the bench's scenarios, which track serial traffic against a model. These are the polarity of every segment against the backplane, the exact rise count at which the divided backplane toggles, pass-through of the display clock, and the stage each chain output reports.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  typedef enum logic {
    BP_FOLLOW = 1'b0,
    BP_DIVIDE = 1'b1
  } bp_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign sync_out = pipe_q[STAGES-1];
endmodule

// File: rtl/segdrv_shift.sv
module segdrv_shift #(
  parameter int NSTAGE = 38,
  parameter int TAP_A  = 30,
  parameter int TAP_B  = 32,
  localparam int NTAP  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  segdrv_pkg::edge_t cl_edge,
  input  logic              sel_n_s,
  input  logic              din_s,
  output logic [NSTAGE-1:0] sr_q,
  output logic [NTAP-1:0]   tap_q
);
  logic              shift_en;
  logic [NSTAGE-1:0] sr_d;

  always_comb begin
    shift_en = cl_edge.fall && !sel_n_s;
    sr_d     = sr_q;
    if (shift_en) sr_d = {sr_q[NSTAGE-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int POS = (g == 0) ? TAP_A : (g == 1) ? TAP_B : NSTAGE;
    logic tap_d;
    always_comb begin
      tap_d = tap_q[g];
      if (cl_edge.rise) tap_d = sr_q[POS-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[g] <= 1'b0;
      else        tap_q[g] <= tap_d;
    end
  end

  // R1: a selected falling edge moves data in by one place
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_edge.fall && !sel_n_s) |=>
      (sr_q == {$past(sr_q[NSTAGE-2:0]), $past(din_s)}));

  // R2: without a selected falling edge the register stays put
  p_hold_unsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cl_edge.fall && !sel_n_s) |=> $stable(sr_q));

  // R8: chain outputs move only after a rising serial edge
  p_tap_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_edge.rise |=> $stable(tap_q));
endmodule

// File: rtl/segdrv_backplane.sv
module segdrv_backplane #(
  parameter int DIV_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dclk_s,
  input  segdrv_pkg::bp_mode_e mode,
  output logic                 bp
);
  logic                dclk_prev_q;
  logic                dclk_rise;
  logic [DIV_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    dclk_rise = dclk_s && !dclk_prev_q;
    cnt_d     = cnt_q;
    if (dclk_rise) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_prev_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      dclk_prev_q <= dclk_s;
      cnt_q       <= cnt_d;
    end
  end

  always_comb begin
    if (mode == segdrv_pkg::BP_DIVIDE) bp = cnt_q[DIV_BITS-1];
    else                               bp = dclk_s;
  end

  // R6: in divide mode the backplane only moves after a display clock rise
  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == segdrv_pkg::BP_DIVIDE && $past(mode) == segdrv_pkg::BP_DIVIDE
     && !$past(dclk_s && !dclk_prev_q)) |-> $stable(bp));
endmodule

// File: rtl/segdrv_top.sv
module segdrv_top #(
  parameter int NSTAGE   = 38,
  parameter int TAP_A    = 30,
  parameter int TAP_B    = 32,
  parameter int DIV_BITS = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              sel_n,
  input  logic              load,
  input  logic              disp_clk,
  input  logic              bp_mode,
  output logic [NSTAGE-1:0] seg_out,
  output logic              bp_out,
  output logic [2:0]        chain_out
);
  import segdrv_pkg::*;

  localparam int NSYNC = 6;

  logic             rst_pipe_q [2];
  logic             rst_i_n;
  logic [NSYNC-1:0] raw_in, syn;
  logic             cl_s, din_s, sel_s, ld_s, dclk_s, mode_s;
  logic             cl_prev_q;
  edge_t            cl_edge;
  logic [NSTAGE-1:0] sr, lat_q, lat_d;
  bp_mode_e          mode_e;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q[0] <= 1'b0;
      rst_pipe_q[1] <= 1'b0;
    end else begin
      rst_pipe_q[0] <= 1'b1;
      rst_pipe_q[1] <= rst_pipe_q[0];
    end
  end
  assign rst_i_n = rst_pipe_q[1];

  assign raw_in = {bp_mode, disp_clk, load, sel_n, ser_din, ser_clk};

  segdrv_sync #(.WIDTH(NSYNC), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .async_in(raw_in), .sync_out(syn)
  );
  assign {mode_s, dclk_s, ld_s, sel_s, din_s, cl_s} = syn;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cl_prev_q <= 1'b0;
    else          cl_prev_q <= cl_s;
  end

  always_comb begin
    cl_edge.rise = cl_s && !cl_prev_q;
    cl_edge.fall = !cl_s && cl_prev_q;
  end

  segdrv_shift #(.NSTAGE(NSTAGE), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .cl_edge(cl_edge), .sel_n_s(sel_s),
    .din_s(din_s), .sr_q(sr), .tap_q(chain_out)
  );

  always_comb begin
    lat_d = lat_q;
    if (ld_s) lat_d = sr;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) lat_q <= '0;
    else          lat_q <= lat_d;
  end

  assign mode_e = bp_mode_e'(mode_s);

  segdrv_backplane #(.DIV_BITS(DIV_BITS)) u_bp (
    .clk(clk), .rst_n(rst_i_n), .dclk_s(dclk_s), .mode(mode_e), .bp(bp_out)
  );

  assign seg_out = lat_q ^ {NSTAGE{bp_out}};

  // R3: strobe high copies the register
  p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    ld_s |=> (lat_q == $past(sr)));

  // R4: strobe low holds the latch
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ld_s |=> $stable(lat_q));
endmodule

// File: tb/tb_segdrv_top.sv
module tb_segdrv_top;
  localparam int N  = 38;
  localparam int TA = 30;
  localparam int TB = 32;

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_din, sel_n, load, disp_clk, bp_mode;
  logic [N-1:0] seg_out;
  logic         bp_out;
  logic [2:0]   chain_out;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_sr, m_lat;
  logic [2:0]   m_tap;

  always #2 clk = ~clk;

  segdrv_top dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .sel_n(sel_n), .load(load), .disp_clk(disp_clk), .bp_mode(bp_mode),
    .seg_out(seg_out), .bp_out(bp_out), .chain_out(chain_out)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] taps_of(input logic [N-1:0] v);
    return {v[N-1], v[TB-1], v[TA-1]};
  endfunction

  function automatic logic [N-1:0] seg_exp(input logic [N-1:0] lat, input logic bp);
    return lat ^ {N{bp}};
  endfunction

  task automatic check_segs(input string req);
    chk(seg_out == seg_exp(m_lat, bp_out), req, 64'(seg_out), 64'(seg_exp(m_lat, bp_out)));
  endtask

  // one serial bit: falls, then rises
  task automatic shift_bit(input logic d, input logic s_n);
    ser_din = d;
    sel_n   = s_n;
    wait_cyc(3);
    ser_clk = 1'b0;
    wait_cyc(6);
    if (!s_n) m_sr = {m_sr[N-2:0], d};
    if (load) m_lat = m_sr;
    chk(chain_out == m_tap, "R8 taps hold until rise", 64'(chain_out), 64'(m_tap));
    ser_clk = 1'b1;
    wait_cyc(6);
    m_tap = taps_of(m_sr);
    chk(chain_out == m_tap, "R8 taps after rise", 64'(chain_out), 64'(m_tap));
  endtask

  task automatic pulse_load();
    load = 1'b1;
    wait_cyc(6);
    m_lat = m_sr;
    load = 1'b0;
    wait_cyc(6);
  endtask

  task automatic dclk_rises(input int n);
    for (int i = 0; i < n; i++) begin
      disp_clk = 1'b1;
      wait_cyc(3);
      disp_clk = 1'b0;
      wait_cyc(3);
    end
    wait_cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; ser_clk = 1'b1; ser_din = 1'b0; sel_n = 1'b1;
    load = 1'b0; disp_clk = 1'b0; bp_mode = 1'b1;
    m_sr = '0; m_lat = '0; m_tap = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(8);

    // R9 reset state
    chk(bp_out == 1'b0, "R9 bp after reset", 64'(bp_out), 64'h0);
    chk(seg_out == '0, "R9 segments blank", 64'(seg_out), 64'h0);
    chk(chain_out == 3'b000, "R9 taps cleared", 64'(chain_out), 64'h0);

    // R6 divide by 256
    dclk_rises(127);
    chk(bp_out == 1'b0, "R6 bp low after 127 rises", 64'(bp_out), 64'h0);
    dclk_rises(1);
    chk(bp_out == 1'b1, "R6 bp high after 128 rises", 64'(bp_out), 64'h1);
    dclk_rises(127);
    chk(bp_out == 1'b1, "R6 bp high after 255 rises", 64'(bp_out), 64'h1);
    dclk_rises(1);
    chk(bp_out == 1'b0, "R6 bp low after 256 rises", 64'(bp_out), 64'h0);

    // R7 follow mode
    bp_mode = 1'b0;
    disp_clk = 1'b1;
    wait_cyc(6);
    chk(bp_out == 1'b1, "R7 bp follows high", 64'(bp_out), 64'h1);
    disp_clk = 1'b0;
    wait_cyc(6);
    chk(bp_out == 1'b0, "R7 bp follows low", 64'(bp_out), 64'h0);

    // R2 deselected shifts ignored
    for (int i = 0; i < 10; i++) shift_bit(1'b1, 1'b1);
    pulse_load();
    chk(seg_out == seg_exp('0, bp_out), "R2 deselected data ignored",
        64'(seg_out), 64'(seg_exp('0, bp_out)));

    // R1/R8 walking one reaches each tap
    shift_bit(1'b1, 1'b0);
    for (int i = 1; i < N; i++) begin
      shift_bit(1'b0, 1'b0);
      if (i == TA - 1)
        chk(chain_out == 3'b001, "R1 one at stage 30", 64'(chain_out), 64'h1);
      if (i == TB - 1)
        chk(chain_out == 3'b010, "R1 one at stage 32", 64'(chain_out), 64'h2);
    end
    chk(chain_out == 3'b100, "R1 one at stage 38", 64'(chain_out), 64'h4);
    pulse_load();
    check_segs("R5 single segment on");

    // random traffic
    for (int i = 0; i < 300; i++) begin
      shift_bit(1'($urandom), ($urandom % 4) == 0);
      check_segs("R4 latch holds while shifting");
      if (($urandom % 8) == 0) begin
        pulse_load();
        check_segs("R3 load copies register");
      end
      if (($urandom % 16) == 0) begin
        disp_clk = ~disp_clk;
        wait_cyc(6);
        chk(bp_out == disp_clk, "R7 bp follows display clock",
            64'(bp_out), 64'(disp_clk));
        check_segs("R5 polarity against backplane");
      end
    end

    // R3 transparent while load held high
    load = 1'b1;
    wait_cyc(6);
    m_lat = m_sr;
    for (int i = 0; i < 40; i++) begin
      shift_bit(1'($urandom), 1'b0);
      check_segs("R3 transparent latch");
    end
    load = 1'b0;
    wait_cyc(6);

    // R5 both backplane phases
    disp_clk = 1'b1;
    wait_cyc(6);
    check_segs("R5 segments with bp high");
    disp_clk = 1'b0;
    wait_cyc(6);
    check_segs("R5 segments with bp low");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule